// File: doc/BRIEF.md
# Two-Wire Register Map Slave with Atomic Shadow Commit

This block is a slave on a two-wire (I2C-compatible) serial bus. It gives an external master byte-wide access to a small register map. The master can write one byte or a run of bytes, and can read back from a chosen address, either one byte or a run of bytes. The bus inputs reach the block already synchronised and sampled at the core clock rate, well above the bus rate. The block returns one output, the low-drive enable for the data line.

One window of the map is double-buffered. Bus writes into that window land in a shadow copy. The whole shadow is copied to the live copy in the cycle that a STOP condition is seen, and only if a byte in the window was written during that session. The logic that uses the data reads the live copy through a separate port, so it never sees a partly written window.

Inside the map there are three special registers:
- a command register, write-only, that is decoded when STOP is seen;
- a one-shot trigger register;
- a read-only status register.

After a commit, or after a command that was accepted, the block is busy for a programmable number of cycles. While it is busy it does not acknowledge its own device address, so the master can poll until the block is ready.

Top module: `twi_shadow_regmap`

## Requirements
- R1: The block acknowledges a control byte whose upper seven bits are 1101011, and leaves every other control byte unacknowledged. Bit 0 of the control byte selects the direction: 1 means read and 0 means write.
- R2: In a write session, the first byte after the control byte loads the pointer. Each later byte is stored at the pointer, and the pointer then advances by one.
- R3: The pointer saturates at the last address, LAST_ADDR (default 0x3F). A word address above LAST_ADDR is clamped to LAST_ADDR. Writes and reads past the end both stay at LAST_ADDR.
- R4: In a read session, data is returned from the pointer and the pointer advances after each byte. Bits are sent MSB first. A random read is a write session that only sets the pointer, followed by a repeated START and a read control byte.
- R5: When the master does not acknowledge a byte the block has sent, the block releases the data line and drives it no more until the next START.
- R6: The buffered window covers addresses 0x02 to 0x09. Bus writes and bus reads in this window use the shadow copy. The consumer port shows the live copy, which changes only in the STOP cycle of a session that wrote into the window. The whole window is copied in that one cycle.
- R7: A commit, or an accepted command, makes `busy_o` high for BUSY_CYC cycles, starting right after the STOP cycle. While `busy_o` is high, the device address is not acknowledged.
- R8: The command register sits at address 0x0A and is applied at STOP. Code 0x45 gives a one-cycle store pulse. Code 0x31 turns the subcarrier enable on. Code 0x52 gives a one-cycle reset pulse, and code 0x30 turns the subcarrier enable off, but each of these two is accepted only when it is the only data byte written in the session. The register reads back as 0x00.
- R9: Writing 0x01 to the trigger register at address 0x0C gives exactly one `insert_o` pulse. The register then clears itself, so a later read returns 0x00.
- R10: The status register at address 0x0B reads as {5'b0, loop_run_i, ta_air_i, pilot_i}. Bus writes to it have no effect.
- R11: A START or a STOP that arrives in the middle of a byte drops that byte, and nothing is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised bus clock level |
| sda_i | input | 1 | Synchronised bus data level |
| sda_oe_o | output | 1 | High means the data line is pulled low |
| pilot_i | input | 1 | Status bit 0: pilot present |
| ta_air_i | input | 1 | Status bit 1: traffic flag currently on air |
| loop_run_i | input | 1 | Status bit 2: dynamic text loop running |
| cons_addr_i | input | 8 | Consumer read address |
| cons_data_o | output | 8 | Consumer read data (live copy in the buffered window) |
| busy_o | output | 1 | Busy after a commit or an accepted command |
| store_o | output | 1 | One-cycle store request |
| soft_rst_o | output | 1 | One-cycle reset request |
| carrier_en_o | output | 1 | Subcarrier enable level, 1 after reset |
| insert_o | output | 1 | One-cycle insertion event from the trigger |

## Verification
The window commit and the command decode are both applied on the same STOP. The bench provokes this with a single page write that puts a byte at 0x09, which is the last buffered address, followed by a command byte at 0x0A. It then checks that the consumer view of 0x09 changes in the very clock cycle in which the store pulse appears. A second session of the same shape carries the subcarrier-off code instead. There the bench checks that the window still commits while the command is refused, because the command was not the only data byte in the session.

// File: rtl/twi_regmap_pkg.sv
package twi_regmap_pkg;
  typedef enum logic [2:0] {
    LK_IDLE,
    LK_DEV,
    LK_WORD,
    LK_WDATA,
    LK_READ
  } lk_state_e;

  localparam logic [7:0] CMD_STORE   = 8'h45;
  localparam logic [7:0] CMD_RESET   = 8'h52;
  localparam logic [7:0] CMD_CARR_OFF = 8'h30;
  localparam logic [7:0] CMD_CARR_ON = 8'h31;
endpackage

// File: rtl/twi_line_cond.sv
module twi_line_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // data edge while clock held high
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/twi_link.sv
module twi_link
  import twi_regmap_pkg::*;
#(
  parameter int         LAST_ADDR = 63,
  parameter logic [6:0] DEV_ADDR  = 7'b1101011
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       sda_i,
  input  logic       busy_i,
  input  logic [7:0] rdata_i,
  output logic [7:0] raddr_o,
  output logic       wr_o,
  output logic [7:0] waddr_o,
  output logic [7:0] wdata_o,
  output logic       sda_oe_o
);
  localparam logic [7:0] LAST = 8'(LAST_ADDR);

  lk_state_e  st_q;
  logic [3:0] cnt_q;
  logic       ack_q;
  logic [7:0] sh_q, tx_q, ptr_q, wa_q, wd_q;
  logic       wr_q;
  logic [7:0] ptr_nxt;
  logic       word_load;

  assign ptr_nxt   = (ptr_q == LAST) ? ptr_q : ptr_q + 8'd1;
  assign word_load = (st_q == LK_WORD) && scl_fall_i && (cnt_q == 4'd8) && !start_i && !stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= LK_IDLE;
      cnt_q <= '0;
      ack_q <= 1'b0;
      sh_q  <= '0;
      tx_q  <= 8'hFF;
      ptr_q <= '0;
      wa_q  <= '0;
      wd_q  <= '0;
      wr_q  <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      if (start_i) begin
        st_q  <= LK_DEV;
        cnt_q <= '0;
        ack_q <= 1'b0;
      end else if (stop_i) begin
        st_q  <= LK_IDLE;
        cnt_q <= '0;
        ack_q <= 1'b0;
      end else if (st_q == LK_READ) begin
        if (scl_fall_i) begin
          if (cnt_q == 4'd9) begin
            tx_q  <= rdata_i;
            ptr_q <= ptr_nxt;
            cnt_q <= '0;
            ack_q <= 1'b0;
          end else if (cnt_q < 4'd8) begin
            tx_q  <= {tx_q[6:0], 1'b1};
            cnt_q <= cnt_q + 4'd1;
          end
        end else if (scl_rise_i && cnt_q == 4'd8) begin
          if (sda_i) st_q <= LK_IDLE;   // master NACK
          else       cnt_q <= 4'd9;
        end
      end else if (st_q != LK_IDLE) begin
        if (scl_rise_i && cnt_q < 4'd8) begin
          sh_q  <= {sh_q[6:0], sda_i};
          cnt_q <= cnt_q + 4'd1;
        end else if (scl_fall_i && cnt_q == 4'd8) begin
          cnt_q <= 4'd9;
          ack_q <= 1'b1;
          case (st_q)
            LK_DEV: begin
              if (sh_q[7:1] != DEV_ADDR || busy_i) begin
                st_q  <= LK_IDLE;
                cnt_q <= '0;
                ack_q <= 1'b0;
              end else if (sh_q[0]) begin
                st_q <= LK_READ;
              end else begin
                st_q <= LK_WORD;
              end
            end
            LK_WORD: begin
              ptr_q <= (sh_q > LAST) ? LAST : sh_q;
              st_q  <= LK_WDATA;
            end
            default: begin
              wr_q  <= 1'b1;
              wa_q  <= ptr_q;
              wd_q  <= sh_q;
              ptr_q <= ptr_nxt;
            end
          endcase
        end else if (scl_fall_i && cnt_q == 4'd9) begin
          cnt_q <= '0;
          ack_q <= 1'b0;
        end
      end
    end
  end

  assign sda_oe_o = (cnt_q == 4'd9 && ack_q) ||
                    (st_q == LK_READ && cnt_q < 4'd8 && !tx_q[7]);
  assign raddr_o  = ptr_q;
  assign wr_o     = wr_q;
  assign waddr_o  = wa_q;
  assign wdata_o  = wd_q;

  assert_no_ack_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == LK_DEV && scl_fall_i && cnt_q == 4'd8 && busy_i && !start_i && !stop_i) |=> !sda_oe_o);
  assert_ptr_sat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q == LAST && !word_load) |=> ptr_q == LAST);
  assert_idle_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == LK_IDLE) |-> !sda_oe_o);
endmodule

// File: rtl/twi_rf_map.sv
module twi_rf_map #(
  parameter int LAST_ADDR = 63,
  parameter int BUF_LO    = 2,
  parameter int BUF_N     = 8,
  parameter int CMD_ADDR  = 10,
  parameter int STAT_ADDR = 11,
  parameter int TRIG_ADDR = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] waddr_i,
  input  logic [7:0] wdata_i,
  input  logic [7:0] raddr_i,
  output logic [7:0] rdata_o,
  input  logic       commit_i,
  output logic       dirty_o,
  input  logic [2:0] status_i,
  input  logic [7:0] cons_addr_i,
  output logic [7:0] cons_data_o,
  output logic       insert_o
);
  localparam int DEPTH = LAST_ADDR + 1;
  localparam logic [7:0] A_CMD  = 8'(CMD_ADDR);
  localparam logic [7:0] A_STAT = 8'(STAT_ADDR);
  localparam logic [7:0] A_TRIG = 8'(TRIG_ADDR);

  logic [7:0]            mem_q [DEPTH];
  logic [BUF_N-1:0][7:0] live_q;
  logic                  dirty_q, trig_q, ins_q;
  logic                  w_plain, w_buf;

  assign w_plain = wr_i && waddr_i != A_CMD && waddr_i != A_STAT && waddr_i != A_TRIG;
  assign w_buf   = w_plain && waddr_i >= 8'(BUF_LO) && waddr_i < 8'(BUF_LO + BUF_N);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (w_plain && waddr_i == 8'(i)) mem_q[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dirty_q <= 1'b0;
      trig_q  <= 1'b0;
      ins_q   <= 1'b0;
    end else begin
      if (commit_i) dirty_q <= 1'b0;
      if (w_buf)    dirty_q <= 1'b1;
      ins_q <= trig_q;
      if (trig_q) trig_q <= 1'b0;
      if (wr_i && waddr_i == A_TRIG) trig_q <= (wdata_i == 8'd1);
    end
  end

  // live copy of the buffered window, whole window per commit
  for (genvar g = 0; g < BUF_N; g++) begin : g_live
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       live_q[g] <= '0;
      else if (commit_i) live_q[g] <= mem_q[BUF_LO + g];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (raddr_i == 8'(i)) rdata_o = mem_q[i];
    if (raddr_i == A_STAT) rdata_o = {5'b0, status_i};
    if (raddr_i == A_CMD)  rdata_o = '0;
    if (raddr_i == A_TRIG) rdata_o = {7'b0, trig_q};
  end

  always_comb begin
    cons_data_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (cons_addr_i == 8'(i)) cons_data_o = mem_q[i];
    for (int i = 0; i < BUF_N; i++)
      if (cons_addr_i == 8'(BUF_LO + i)) cons_data_o = live_q[i];
  end

  assign dirty_o  = dirty_q;
  assign insert_o = ins_q;

  assert_trig_once_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q && !(wr_i && waddr_i == A_TRIG)) |=> (!trig_q && insert_o));
  assert_commit_dirty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> dirty_q);
endmodule

// File: rtl/twi_rf_ctrl.sv
module twi_rf_ctrl
  import twi_regmap_pkg::*;
#(
  parameter int CMD_ADDR = 10,
  parameter int BUSY_CYC = 400
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stop_i,
  input  logic       wr_i,
  input  logic [7:0] waddr_i,
  input  logic [7:0] wdata_i,
  input  logic       dirty_i,
  output logic       commit_o,
  output logic       busy_o,
  output logic       store_o,
  output logic       soft_rst_o,
  output logic       carrier_en_o
);
  localparam int BW = $clog2(BUSY_CYC + 1);

  logic [1:0]    nbytes_q;
  logic          pend_q;
  logic [7:0]    cmd_q;
  logic [BW-1:0] busy_q;
  logic          store_q, srst_q, carr_q;
  logic          sole, cmd_go;

  assign sole     = (nbytes_q == 2'd1);
  assign commit_o = stop_i && dirty_i;

  always_comb begin
    cmd_go = 1'b0;
    if (pend_q) begin
      case (cmd_q)
        CMD_STORE, CMD_CARR_ON:   cmd_go = 1'b1;
        CMD_RESET, CMD_CARR_OFF:  cmd_go = sole;
        default:                  cmd_go = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nbytes_q <= '0;
      pend_q   <= 1'b0;
      cmd_q    <= '0;
      busy_q   <= '0;
      store_q  <= 1'b0;
      srst_q   <= 1'b0;
      carr_q   <= 1'b1;
    end else begin
      store_q <= 1'b0;
      srst_q  <= 1'b0;
      if (wr_i) begin
        if (nbytes_q != 2'd3) nbytes_q <= nbytes_q + 2'd1;
        if (waddr_i == 8'(CMD_ADDR)) begin
          pend_q <= 1'b1;
          cmd_q  <= wdata_i;
        end
      end
      if (stop_i) begin
        nbytes_q <= '0;
        pend_q   <= 1'b0;
        if (cmd_go) begin
          case (cmd_q)
            CMD_STORE:    store_q <= 1'b1;
            CMD_RESET:    srst_q  <= 1'b1;
            CMD_CARR_OFF: carr_q  <= 1'b0;
            default:      carr_q  <= 1'b1;
          endcase
        end
        if (cmd_go || dirty_i) busy_q <= BW'(BUSY_CYC);
      end else if (busy_q != '0) begin
        busy_q <= busy_q - 1'b1;
      end
    end
  end

  assign busy_o       = (busy_q != '0);
  assign store_o      = store_q;
  assign soft_rst_o   = srst_q;
  assign carrier_en_o = carr_q;

  assert_busy_after_commit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> busy_o);
  assert_cmd_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({store_o, soft_rst_o}));
  assert_sole_reset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(soft_rst_o) |-> $past(nbytes_q == 2'd1));
endmodule

// File: rtl/twi_shadow_regmap.sv
module twi_shadow_regmap #(
  parameter int         LAST_ADDR = 63,
  parameter logic [6:0] DEV_ADDR  = 7'b1101011,
  parameter int         BUF_LO    = 2,
  parameter int         BUF_N     = 8,
  parameter int         CMD_ADDR  = 10,
  parameter int         STAT_ADDR = 11,
  parameter int         TRIG_ADDR = 12,
  parameter int         BUSY_CYC  = 400
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic       pilot_i,
  input  logic       ta_air_i,
  input  logic       loop_run_i,
  input  logic [7:0] cons_addr_i,
  output logic [7:0] cons_data_o,
  output logic       busy_o,
  output logic       store_o,
  output logic       soft_rst_o,
  output logic       carrier_en_o,
  output logic       insert_o
);
  logic       rise, fall, start, stop;
  logic [7:0] raddr, rdata, waddr, wdata;
  logic       wr, dirty, commit;

  twi_line_cond u_cond (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_rise_o(rise), .scl_fall_o(fall), .start_o(start), .stop_o(stop)
  );

  twi_link #(.LAST_ADDR(LAST_ADDR), .DEV_ADDR(DEV_ADDR)) u_link (
    .clk_i, .rst_ni,
    .scl_rise_i(rise), .scl_fall_i(fall), .start_i(start), .stop_i(stop),
    .sda_i, .busy_i(busy_o), .rdata_i(rdata), .raddr_o(raddr),
    .wr_o(wr), .waddr_o(waddr), .wdata_o(wdata), .sda_oe_o
  );

  twi_rf_map #(
    .LAST_ADDR(LAST_ADDR), .BUF_LO(BUF_LO), .BUF_N(BUF_N),
    .CMD_ADDR(CMD_ADDR), .STAT_ADDR(STAT_ADDR), .TRIG_ADDR(TRIG_ADDR)
  ) u_map (
    .clk_i, .rst_ni, .wr_i(wr), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(raddr), .rdata_o(rdata), .commit_i(commit), .dirty_o(dirty),
    .status_i({loop_run_i, ta_air_i, pilot_i}),
    .cons_addr_i, .cons_data_o, .insert_o
  );

  twi_rf_ctrl #(.CMD_ADDR(CMD_ADDR), .BUSY_CYC(BUSY_CYC)) u_ctrl (
    .clk_i, .rst_ni, .stop_i(stop), .wr_i(wr), .waddr_i(waddr),
    .wdata_i(wdata), .dirty_i(dirty), .commit_o(commit), .busy_o,
    .store_o, .soft_rst_o, .carrier_en_o
  );
endmodule

// File: tb/sim_twi_shadow_regmap.sv
`timescale 1ns/1ps
module sim_twi_shadow_regmap;
  localparam logic [7:0] DW = 8'hD6, DR = 8'hD7;

  logic clk = 0, rst_n = 0;
  logic scl = 1, sda_m = 1;
  logic pilot = 0, ta = 0, loopr = 0;
  logic [7:0] cons_addr = 8'h02;
  logic sda_oe, busy, store, srst, carr, ins;
  logic [7:0] cons_data;
  wire sda_line = sda_m & ~sda_oe;

  int errors = 0, checks = 0;
  int cyc = 0, store_cyc = -1, cons_cyc = -1, store_cnt = 0, srst_cnt = 0, ins_cnt = 0;
  logic [7:0] last_cons = 0;
  bit done = 0;

  always #10 clk = ~clk;

  twi_shadow_regmap u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .pilot_i(pilot), .ta_air_i(ta), .loop_run_i(loopr),
    .cons_addr_i(cons_addr), .cons_data_o(cons_data), .busy_o(busy),
    .store_o(store), .soft_rst_o(srst), .carrier_en_o(carr), .insert_o(ins)
  );

  always @(posedge clk) begin
    cyc++;
    if (store) begin store_cnt++; store_cyc = cyc; end
    if (srst) srst_cnt++;
    if (ins) ins_cnt++;
    if (cons_data !== last_cons) begin cons_cyc = cyc; last_cons = cons_data; end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qw(); repeat (4) @(negedge clk); endtask
  task automatic settle(); repeat (460) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1; qw(); scl = 1; qw(); sda_m = 0; qw(); scl = 0; qw();
  endtask
  task automatic i2c_stop();
    sda_m = 0; qw(); scl = 1; qw(); sda_m = 1; qw();
  endtask
  task automatic bits(input int n);
    for (int i = 0; i < n; i++) begin
      sda_m = 1; qw(); scl = 1; qw(); qw(); scl = 0; qw();
    end
  endtask
  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qw(); scl = 1; qw(); qw(); scl = 0; qw();
    end
    sda_m = 1; qw(); scl = 1; qw(); ack = !sda_line; qw(); scl = 0; qw();
  endtask
  task automatic rbyte(input bit nack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl = 1; qw(); b[i] = sda_line; qw(); scl = 0; qw();
    end
    sda_m = nack; qw(); scl = 1; qw(); qw(); scl = 0; qw(); sda_m = 1;
  endtask

  task automatic write_bytes(input logic [7:0] wa, input logic [7:0] d0, d1, d2, input int n);
    bit a;
    i2c_start(); wbyte(DW, a); wbyte(wa, a);
    wbyte(d0, a);
    if (n > 1) wbyte(d1, a);
    if (n > 2) wbyte(d2, a);
    i2c_stop(); settle();
  endtask
  task automatic read_bytes(input logic [7:0] ra, input int n, output logic [7:0] r0, r1, r2);
    bit a;
    r1 = 0; r2 = 0;
    i2c_start(); wbyte(DW, a); wbyte(ra, a);
    i2c_start(); wbyte(DR, a);
    rbyte(n == 1, r0);
    if (n > 1) rbyte(n == 2, r1);
    if (n > 2) rbyte(1, r2);
    i2c_stop();
  endtask

  task automatic t_reset();
    chk("R5 reset sda_oe", sda_oe, 0);
    chk("R7 reset busy", busy, 0);
    chk("R8 reset carrier", carr, 1);
    chk("R6 reset live", cons_data, 0);
  endtask

  task automatic t_addr();
    bit a;
    i2c_start(); wbyte(8'hAA, a); i2c_stop();
    chk("R1 foreign address nack", a, 0);
    i2c_start(); wbyte(DW, a); i2c_stop();
    chk("R1 own address ack", a, 1);
    i2c_start(); wbyte(DR, a); chk("R1 own read ack", a, 1);
    begin logic [7:0] d; rbyte(1, d); end
    i2c_stop();
  endtask

  task automatic t_page();
    logic [7:0] r0, r1, r2;
    write_bytes(8'h10, 8'hA1, 8'hB2, 8'hC3, 3);
    read_bytes(8'h10, 3, r0, r1, r2);
    chk("R2 page byte0", r0, 8'hA1);
    chk("R4 seq byte1", r1, 8'hB2);
    chk("R4 seq byte2", r2, 8'hC3);
    read_bytes(8'h11, 1, r0, r1, r2);
    chk("R4 random read", r0, 8'hB2);
  endtask

  task automatic t_sat();
    logic [7:0] r0, r1, r2;
    write_bytes(8'h3E, 8'h11, 8'h22, 8'h33, 3);
    read_bytes(8'h3E, 3, r0, r1, r2);
    chk("R3 below end", r0, 8'h11);
    chk("R3 saturated write", r1, 8'h33);
    chk("R3 saturated read", r2, 8'h33);
    read_bytes(8'hF0, 1, r0, r1, r2);
    chk("R3 clamped word address", r0, 8'h33);
  endtask

  task automatic t_nack();
    bit a; logic [7:0] d;
    i2c_start(); wbyte(DW, a); wbyte(8'h3F, a);
    i2c_start(); wbyte(DR, a); rbyte(1, d);
    chk("R5 released after nack", sda_oe, 0);
    qw(); scl = 1; qw();
    chk("R5 line high after nack", sda_line, 1);
    scl = 0; qw();
    i2c_stop();
  endtask

  task automatic t_commit();
    bit a; logic [7:0] r0, r1, r2;
    cons_addr = 8'h02;
    i2c_start(); wbyte(DW, a); wbyte(8'h02, a); wbyte(8'hA0, a); wbyte(8'hA1, a);
    chk("R6 live held before stop", cons_data, 0);
    i2c_stop(); qw();
    chk("R6 live after stop", cons_data, 8'hA0);
    cons_addr = 8'h03; #1;
    chk("R6 whole window", cons_data, 8'hA1);
    chk("R7 busy after commit", busy, 1);
    i2c_start(); wbyte(DW, a); i2c_stop();
    chk("R7 no ack while busy", a, 0);
    settle();
    chk("R7 busy ended", busy, 0);
    i2c_start(); wbyte(DW, a); i2c_stop();
    chk("R7 ack after busy", a, 1);
    read_bytes(8'h03, 1, r0, r1, r2);
    chk("R6 shadow read", r0, 8'hA1);
  endtask

  task automatic t_cmd();
    logic [7:0] r0, r1, r2;
    write_bytes(8'h0A, 8'h30, 0, 0, 1);
    chk("R8 sole off", carr, 0);
    write_bytes(8'h0A, 8'h31, 0, 0, 1);
    chk("R8 on", carr, 1);
    cons_addr = 8'h09;
    write_bytes(8'h09, 8'h77, 8'h30, 0, 2);
    chk("R8 off refused with two bytes", carr, 1);
    chk("R6 commit beside refused cmd", cons_data, 8'h77);
    write_bytes(8'h09, 8'h5A, 8'h45, 0, 2);
    chk("R8 store pulse count", store_cnt, 1);
    chk("R6 commit and R8 store same cycle", cons_cyc, store_cyc);
    write_bytes(8'h09, 8'h11, 8'h52, 0, 2);
    chk("R8 reset refused with two bytes", srst_cnt, 0);
    write_bytes(8'h0A, 8'h52, 0, 0, 1);
    chk("R8 sole reset", srst_cnt, 1);
    read_bytes(8'h0A, 1, r0, r1, r2);
    chk("R8 command reads zero", r0, 0);
  endtask

  task automatic t_trig();
    logic [7:0] r0, r1, r2;
    write_bytes(8'h0C, 8'h01, 0, 0, 1);
    chk("R9 single insert", ins_cnt, 1);
    read_bytes(8'h0C, 1, r0, r1, r2);
    chk("R9 self cleared", r0, 0);
  endtask

  task automatic t_status();
    logic [7:0] r0, r1, r2;
    pilot = 1; ta = 0; loopr = 1;
    read_bytes(8'h0B, 1, r0, r1, r2);
    chk("R10 status read", r0, 8'h05);
    write_bytes(8'h0B, 8'hFF, 0, 0, 1);
    read_bytes(8'h0B, 1, r0, r1, r2);
    chk("R10 write ignored", r0, 8'h05);
    ta = 1;
    read_bytes(8'h0B, 1, r0, r1, r2);
    chk("R10 ta on air", r0, 8'h07);
  endtask

  task automatic t_abort();
    bit a; logic [7:0] r0, r1, r2;
    write_bytes(8'h20, 8'h42, 8'h43, 0, 2);
    i2c_start(); wbyte(DW, a); wbyte(8'h20, a); bits(4);
    i2c_start(); i2c_stop();
    i2c_start(); wbyte(DW, a); wbyte(8'h21, a); bits(5);
    i2c_stop();
    read_bytes(8'h20, 2, r0, r1, r2);
    chk("R11 start aborts byte", r0, 8'h42);
    chk("R11 stop aborts byte", r1, 8'h43);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_addr();
    t_page();
    t_sat();
    t_nack();
    t_commit();
    t_cmd();
    t_trig();
    t_status();
    t_abort();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule